// File: doc/BRIEF.md
# MDIO Management Register

This block gives a host a single 32-bit register for running one PHY management transaction over a two-wire serial management bus (MDC clock and bidirectional MDIO data). The host writes one command word. That word holds the PHY address, the PHY register address, the write data and a read or write request. The block then sends the full serial frame: a preamble of 32 ones, then the start, opcode, address, turnaround and data fields, most significant bit first. MDC comes from a divider of the system clock, and the divider ratio is programmable.

While a frame is on the wire, a busy bit in the register stays set. The host polls this bit and waits for it to clear before and after each access. When a read finishes, the 16 bits returned by the PHY appear in the upper half of the register. A not-valid bit marks a read in which the PHY did not take the line low during the second turnaround bit. The pad driver sits outside the block. The block only provides the output value, an output enable, and the sampled input.

Top module: `mdio_mgmt_reg`

## Requirements
- R1: In the command word, bits 15:11 hold the PHY address and bits 10:6 hold the register address. Bit 1 set requests a read. Otherwise, bit 0 set requests a write. For a write, bits 31:16 hold the 16-bit data to send.
- R2: Each frame is 64 MDC cycles long, sent MSB first. It is 32 ones, then start `01`, then opcode `10` (read) or `01` (write), then 5 PHY address bits, then 5 register address bits, then turnaround, then 16 data bits. On a write the turnaround is `10`.
- R3: Busy (status bit 3) rises in the cycle after an accepted command. It stays high for exactly 128 × H system clock cycles, where H is the effective half-period, and then clears.
- R4: MDC is low while idle. During a transfer, MDC toggles every H system clocks, starting low, with H = `mdc_half`. A half-period value of 0 acts as 1.
- R5: The output enable is low while idle. On a write it stays high for all 64 bits. On a read it is high for bits 0 to 45 and low from the first turnaround bit onward.
- R6: When a read completes, the 16 data bits sampled on MDC rising edges appear in status bits 31:16, first bit received in bit 31.
- R7: The not-valid flag (status bit 2) is set at the end of a read if MDIO was high at the rising MDC edge of the second turnaround bit. Every newly accepted command clears it.
- R8: After reset the status word reads with the PHY address field equal to the `DEF_PHY` parameter and every other bit zero.
- R9: A command written while busy is set has no effect on the fields, the frame or the busy timing.
- R10: A command word with bits 1 and 0 both clear starts no transfer and leaves the status word unchanged.
- R11: Status bits 15:6 echo the addresses of the last accepted command. After a write, status bits 31:16 hold the data that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | One-cycle strobe that writes the command word |
| cmd_wdata | input | 32 | Command word (addresses, data, op bits) |
| mdc_half | input | DIVW | MDC half-period in system clocks (0 treated as 1) |
| status_rdata | output | 32 | Data, addresses, busy (bit 3), not-valid (bit 2) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
Busy rises in the cycle after the edge that accepts a command. It stays high for 128 × H cycles, and MDC toggles at each H-cycle boundary counted from that edge. Read data and the not-valid flag change in the same cycle that busy clears. The bench model counts clock edges from the accepting edge. At every falling clock edge it predicts busy and MDC and compares them with the outputs. Field and data checks are made only after the model itself shows the transfer over, plus one further cycle. The PHY model drives MDIO on falling MDC edges, so each bit is stable for a full half-period before the block samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN  = 32;
  localparam int FRAME_W  = PRE_LEN + 32;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int TA_POS   = PRE_LEN + 14;
  localparam int DATA_POS = PRE_LEN + 16;

  localparam int ST_BUSY  = 3;
  localparam int ST_NVAL  = 2;
  localparam int CMD_RD   = 1;
  localparam int CMD_WR   = 0;

  typedef struct packed {
    logic [15:0] data;
    logic [4:0]  phy;
    logic [4:0]  regad;
  } mdio_fields_t;

  function automatic logic [FRAME_W-1:0] mdio_frame(input logic rd,
                                                     input logic [4:0] pa,
                                                     input logic [4:0] ra,
                                                     input logic [15:0] d);
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] dd;
    opc = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    dd  = rd ? 16'hFFFF : d;
    return {{PRE_LEN{1'b1}}, 2'b01, opc, pa, ra, ta, dd};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half_i,
  output logic            mdc,
  output logic            rise_stb,
  output logic            fall_stb
);
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic            mdc_q, mdc_d;
  logic [DIVW-1:0] half_eff;
  logic            tick;

  always_comb begin
    half_eff = (half_i == '0) ? DIVW'(1) : half_i;
    tick     = run && (cnt_q >= half_eff - DIVW'(1));
    cnt_d    = cnt_q;
    mdc_d    = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic [15:0] rdata,
  output logic        ta_fail,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_POS + 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic               act_q, act_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               rd_q, rd_d;
  logic [15:0]        rsh_q, rsh_d;
  logic               taf_q, taf_d;

  always_comb begin
    act_d = act_q;
    sh_d  = sh_q;
    idx_d = idx_q;
    rd_d  = rd_q;
    rsh_d = rsh_q;
    taf_d = taf_q;
    if (start) begin
      act_d = 1'b1;
      sh_d  = mdio_frame(op_rd, phy, regad, wdata);
      idx_d = '0;
      rd_d  = op_rd;
      rsh_d = '0;
      taf_d = 1'b0;
    end else if (act_q) begin
      if (rise_stb && rd_q) begin
        if (idx_q == TA2_IDX) taf_d = mdio_i;
        if (idx_q >= DAT_IDX) rsh_d = {rsh_q[14:0], mdio_i};
      end
      if (fall_stb) begin
        if (idx_q == LAST_IDX) begin
          act_d = 1'b0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
          sh_d  = {sh_q[FRAME_W-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sh_q  <= '1;
      idx_q <= '0;
      rd_q  <= 1'b0;
      rsh_q <= '0;
      taf_q <= 1'b0;
    end else begin
      act_q <= act_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
      rd_q  <= rd_d;
      rsh_q <= rsh_d;
      taf_q <= taf_d;
    end
  end

  assign active  = act_q;
  assign done    = act_q && fall_stb && (idx_q == LAST_IDX);
  assign rdata   = rsh_q;
  assign ta_fail = taf_q;
  assign mdio_o  = act_q ? sh_q[FRAME_W-1] : 1'b1;
  assign mdio_oe = act_q && !(rd_q && (idx_q >= TA1_IDX));
endmodule

// File: rtl/mdio_mgmt_reg.sv
module mdio_mgmt_reg
  import mdio_pkg::*;
#(
  parameter int         DIVW    = 8,
  parameter logic [4:0] DEF_PHY = 5'd0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [31:0]     cmd_wdata,
  input  logic [DIVW-1:0] mdc_half,
  output logic [31:0]     status_rdata,
  output logic            mdc,
  output logic            mdio_o,
  output logic            mdio_oe,
  input  logic            mdio_i
);
  mdio_fields_t fld_q, fld_d;
  logic         nval_q, nval_d;
  logic         op_rd_q, op_rd_d;
  logic         busy, done, ta_fail, accept, cmd_rd;
  logic         rise_stb, fall_stb;
  logic [15:0]  rdata;

  assign cmd_rd = cmd_wdata[CMD_RD];
  assign accept = cmd_we && !busy && (cmd_wdata[CMD_RD] || cmd_wdata[CMD_WR]);

  always_comb begin
    fld_d   = fld_q;
    nval_d  = nval_q;
    op_rd_d = op_rd_q;
    if (accept) begin
      fld_d.phy   = cmd_wdata[15:11];
      fld_d.regad = cmd_wdata[10:6];
      if (!cmd_rd) fld_d.data = cmd_wdata[31:16];
      nval_d  = 1'b0;
      op_rd_d = cmd_rd;
    end else if (done && op_rd_q) begin
      fld_d.data = rdata;
      nval_d     = ta_fail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q   <= '{data: 16'h0, phy: DEF_PHY, regad: 5'h0};
      nval_q  <= 1'b0;
      op_rd_q <= 1'b0;
    end else begin
      fld_q   <= fld_d;
      nval_q  <= nval_d;
      op_rd_q <= op_rd_d;
    end
  end

  mdio_clkgen #(.DIVW(DIVW)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half_i   (mdc_half),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .op_rd    (cmd_rd),
    .phy      (cmd_wdata[15:11]),
    .regad    (cmd_wdata[10:6]),
    .wdata    (cmd_wdata[31:16]),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .active   (busy),
    .done     (done),
    .rdata    (rdata),
    .ta_fail  (ta_fail),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  assign status_rdata = {fld_q.data, fld_q.phy, fld_q.regad,
                         2'b00, busy, nval_q, 2'b00};
endmodule

// File: rtl/mdio_mgmt_reg_chk.sv
module mdio_mgmt_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic [31:0] status_rdata,
  input logic        mdc,
  input logic        mdio_oe
);
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !status_rdata[3] && (cmd_wdata[1] || cmd_wdata[0])) |=> status_rdata[3]);

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rdata[3] |-> !mdc);

  // R5
  oe_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rdata[3] |-> !mdio_oe);

  // R7
  nval_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_rdata[2]) |-> $fell(status_rdata[3]));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && status_rdata[3]) |=> $stable(status_rdata[15:6]));
endmodule

bind mdio_mgmt_reg mdio_mgmt_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_we       (cmd_we),
  .cmd_wdata    (cmd_wdata),
  .status_rdata (status_rdata),
  .mdc          (mdc),
  .mdio_oe      (mdio_oe)
);

// File: tb/tb_mdio_mgmt_reg.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_reg;
  logic        clk;
  logic        rst_n;
  logic        cmd_we;
  logic [31:0] cmd_wdata;
  logic [7:0]  mdc_half;
  logic [31:0] status_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  mdio_mgmt_reg #(.DIVW(8), .DEF_PHY(5'd9)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .mdc_half(mdc_half), .status_rdata(status_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int heff();
    return (mdc_half == 8'd0) ? 1 : int'(mdc_half);
  endfunction

  // reference model: cycles since the accepting edge
  bit m_act;
  int m_t;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0;
      m_t   <= 0;
    end else if (!m_act && cmd_we && (cmd_wdata[1] || cmd_wdata[0])) begin
      m_act <= 1'b1;
      m_t   <= 0;
    end else if (m_act) begin
      if (m_t + 1 >= 128 * heff()) m_act <= 1'b0;
      m_t <= m_t + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(status_rdata[3] == m_act, "R3 busy timing", 64'(status_rdata[3]), 64'(m_act));
      chk(mdc == (m_act && ((m_t / heff()) % 2 == 1)), "R4 mdc phase",
          64'(mdc), 64'(m_act && ((m_t / heff()) % 2 == 1)));
      if (!m_act) chk(!mdio_oe, "R5 oe idle", 64'(mdio_oe), 64'd0);
    end
  end

  // PHY model
  int          nrise;
  logic [63:0] cap;
  bit          rd_mode, phy_resp, oe_bad;
  logic [15:0] phy_data;

  always @(posedge mdc) begin
    if (rd_mode && nrise >= 46 && mdio_oe) oe_bad = 1'b1;
    if (rd_mode && nrise < 46 && !mdio_oe) oe_bad = 1'b1;
    if (!rd_mode && !mdio_oe) oe_bad = 1'b1;
    cap   = {cap[62:0], mdio_o};
    nrise = nrise + 1;
  end

  always @(negedge mdc) begin
    mdio_i = 1'b1;
    if (rd_mode && phy_resp) begin
      if (nrise == 47) mdio_i = 1'b0;
      else if (nrise >= 48 && nrise <= 63) mdio_i = phy_data[63 - nrise];
    end
  end

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] pa,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
  endfunction

  task automatic xfer(input logic [31:0] w, input int h, input bit resp,
                      input logic [15:0] pd);
    @(negedge clk);
    mdc_half  = 8'(h);
    rd_mode   = w[1];
    phy_resp  = resp;
    phy_data  = pd;
    nrise     = 0;
    cap       = '0;
    oe_bad    = 1'b0;
    cmd_we    = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_we    = 1'b0;
    cmd_wdata = '0;
    while (m_act) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; cmd_we = 1'b0; cmd_wdata = '0; mdc_half = 8'd2; mdio_i = 1'b1;
    rd_mode = 1'b0; phy_resp = 1'b0; phy_data = '0; nrise = 0; cap = '0; oe_bad = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset value
    chk(status_rdata == {16'h0, 5'd9, 5'd0, 6'd0}, "R8 reset status",
        64'(status_rdata), 64'({16'h0, 5'd9, 5'd0, 6'd0}));
    chk(!mdc && !mdio_oe, "R4 idle mdc/oe", 64'({mdc, mdio_oe}), 64'd0);

    // write, H=2
    w = {16'hBEEF, 5'd5, 5'd17, 4'b0, 2'b01};
    xfer(w, 2, 1'b0, 16'h0);
    chk(cap == exp_frame(1'b0, 5'd5, 5'd17, 16'hBEEF), "R2 write frame",
        cap, exp_frame(1'b0, 5'd5, 5'd17, 16'hBEEF));
    chk(nrise == 64, "R4 write mdc count", 64'(nrise), 64'd64);
    chk(status_rdata[15:6] == {5'd5, 5'd17}, "R1 R11 address echo",
        64'(status_rdata[15:6]), 64'({5'd5, 5'd17}));
    chk(status_rdata[31:16] == 16'hBEEF, "R11 write data echo",
        64'(status_rdata[31:16]), 64'hBEEF);
    chk(!status_rdata[2], "R7 write nval", 64'(status_rdata[2]), 64'd0);
    chk(!oe_bad, "R5 write oe", 64'(oe_bad), 64'd0);

    // read with response, H=3
    w = {16'h0, 5'd12, 5'd2, 4'b0, 2'b10};
    xfer(w, 3, 1'b1, 16'hA5C3);
    chk(cap[63:18] == exp_frame(1'b1, 5'd12, 5'd2, 16'h0) >> 18, "R2 read frame head",
        64'(cap[63:18]), exp_frame(1'b1, 5'd12, 5'd2, 16'h0) >> 18);
    chk(status_rdata[31:16] == 16'hA5C3, "R6 read data",
        64'(status_rdata[31:16]), 64'hA5C3);
    chk(!status_rdata[2], "R7 read ok nval", 64'(status_rdata[2]), 64'd0);
    chk(!oe_bad, "R5 read turnaround release", 64'(oe_bad), 64'd0);

    // read, no PHY response, H=1
    w = {16'h0, 5'd30, 5'd1, 4'b0, 2'b10};
    xfer(w, 1, 1'b0, 16'h0);
    chk(status_rdata[2], "R7 no response nval", 64'(status_rdata[2]), 64'd1);

    // read with response, H=0 behaves as 1
    w = {16'h0, 5'd3, 5'd9, 4'b0, 2'b10};
    xfer(w, 0, 1'b1, 16'h1234);
    chk(!status_rdata[2], "R7 nval cleared", 64'(status_rdata[2]), 64'd0);
    chk(status_rdata[31:16] == 16'h1234, "R6 read data H0",
        64'(status_rdata[31:16]), 64'h1234);
    chk(nrise == 64, "R4 zero divider count", 64'(nrise), 64'd64);

    // R9 command while busy
    @(negedge clk);
    mdc_half = 8'd2; rd_mode = 1'b0; phy_resp = 1'b0; nrise = 0; cap = '0; oe_bad = 1'b0;
    cmd_we = 1'b1; cmd_wdata = {16'h1111, 5'd7, 5'd8, 4'b0, 2'b01};
    @(negedge clk);
    cmd_wdata = '0; cmd_we = 1'b0;
    repeat (40) @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = {16'h2222, 5'd20, 5'd21, 4'b0, 2'b10};
    @(negedge clk);
    cmd_we = 1'b0; cmd_wdata = '0;
    while (m_act) @(negedge clk);
    @(negedge clk);
    chk(status_rdata[31:6] == {16'h1111, 5'd7, 5'd8}, "R9 busy write ignored",
        64'(status_rdata[31:6]), 64'({16'h1111, 5'd7, 5'd8}));
    chk(cap == exp_frame(1'b0, 5'd7, 5'd8, 16'h1111) && nrise == 64, "R9 frame intact",
        cap, exp_frame(1'b0, 5'd7, 5'd8, 16'h1111));

    // R10 no op bits
    cmd_we = 1'b1; cmd_wdata = {16'h3333, 5'd1, 5'd2, 4'b0, 2'b00};
    @(negedge clk);
    cmd_we = 1'b0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    chk(status_rdata == {16'h1111, 5'd7, 5'd8, 6'd0}, "R10 no-op ignored",
        64'(status_rdata), 64'({16'h1111, 5'd7, 5'd8, 6'd0}));

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule